// File: doc/BRIEF.md
# Configuration Lifecycle Sequencer

This block steps a programmable device through its start-up life: held off while power is bad, then an initialization step, one or more bitstream load attempts, wake-up and finally user operation. The loader itself is outside the block. The sequencer sends it a one-cycle start strobe. It then watches per-attempt result flags, which report a data-complete, an identity mismatch, a checksum failure or an illegal command. It also runs its own load timeout.

The block drives two status pins. `ready` is high while configuration is proceeding cleanly. `done` is high once the part has woken up. The three mode pins are latched on the edge where `ready` rises. A sticky status word records why attempts failed and whether the final wake-up was reached.

In automatic-boot mode (mode pins 000) the block can retry a failed load by itself, up to two extra attempts. When no retry remains, it parks with both pins low. Only an external reconfigure pulse of sufficient width or a power cycle releases it.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `pwr_good` is low, or after reset, `ready` and `done` are 0. In the first cycle of the next attempt, `err_status` and `retry_cnt` read 0.
- R2: The clock edge after `pwr_good` is seen high makes `ready` 1. At that same edge `mode_latched` takes the value of `mode_pins`. `load_start` is 1 for exactly the first cycle in which `ready` is 1.
- R3: `rcfg_n` passes through a two-flop synchronizer. A low pulse sampled low on at least MIN_LOW edges restarts configuration: `ready` reads 0 on the third cycle after release and 1 on the fourth. MIN_LOW is ceil(MIN_PULSE_PS/CLK_PERIOD_PS), which is 4 at 25 ns and an 8 ns clock. A shorter pulse has no effect.
- R4: A result error during loading makes `ready` 0 in the next cycle while `done` stays 0. Each error sets its sticky bit in `err_status`: checksum error at bit 0, illegal command at bit 1, identity mismatch at bit 2.
- R5: An error flag that arrives in the same cycle as `att_data_done` wins. The attempt fails and `done` stays 0.
- R6: `att_data_done` without an error makes `done` 1 in the next cycle (wake-up) and sets `err_status` bit 13. The block then stays in user mode with `ready` and `done` both 1.
- R7: User mode is left only by a qualified `rcfg_n` pulse, by `refresh_cmd`, which makes `ready` and `done` 0 in the next cycle, or by `pwr_good` low. Result flags asserted in user mode change neither the outputs nor `err_status`.
- R8: With mode 000 latched and EXTRA_RETRY=1, a failed attempt keeps `ready` low for one cycle. `ready` then rises again with a new `load_start`, and `retry_cnt` goes up by one, to a maximum of 2.
- R9: With no retry left, or in any mode other than 000, a failed attempt parks the block with `ready` and `done` low. `refresh_cmd` is then ignored, and only a qualified `rcfg_n` pulse or a power cycle restarts it.
- R10: An attempt that stays in loading for LOAD_TIMEOUT_CYC cycles without a result fails with `err_status` bit 3 set.
- R11: Error bits accumulate across automatic retries. They are cleared, together with `retry_cnt`, when configuration restarts from a pin pulse, a refresh or a power cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supplies valid; low acts as a power cycle |
| rcfg_n | input | 1 | Asynchronous reconfigure pin, active low |
| mode_pins | input | 3 | Configuration mode selection |
| refresh_cmd | input | 1 | Restart request from a configuration port |
| att_id_err | input | 1 | Loader reports identity mismatch |
| att_crc_err | input | 1 | Loader reports checksum failure |
| att_cmd_err | input | 1 | Loader reports illegal command |
| att_data_done | input | 1 | Loader received all data |
| ready | output | 1 | Configuration proceeding without error |
| done | output | 1 | Wake-up reached, user mode |
| mode_latched | output | 3 | Mode captured at the rise of ready |
| load_start | output | 1 | One-cycle strobe starting a load attempt |
| err_status | output | 32 | Sticky failure causes and done-final flag |
| retry_cnt | output | 2 | Automatic retries used since the last restart |

## Verification
Two pairs of events can land on the same clock edge, and the bench provokes both. In the first, an error flag and the data-complete flag are raised together in the loading cycle. The bench judges this correct when `done` stays low, `ready` falls and the matching status bit is set. In the second, a reconfigure pulse is released while the block is parked after its last retry, with a refresh request applied just before. The bench expects the refresh to be ignored and the pin pulse to restart configuration with the status word and retry count cleared.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR, ST_INIT, ST_LOAD, ST_WAKE, ST_USER, ST_FAIL, ST_HALT
  } cfg_state_e;

  localparam int STAT_W   = 32;
  localparam int BIT_CRC  = 0;
  localparam int BIT_CMD  = 1;
  localparam int BIT_ID   = 2;
  localparam int BIT_TMO  = 3;
  localparam int BIT_DONE = 13;

  localparam logic [2:0] MODE_AUTO = 3'b000;

  // cycles needed to cover a pulse width, rounded up
  function automatic int unsigned min_low_cycles(int unsigned pulse_ps,
                                                 int unsigned period_ps);
    return (pulse_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic logic retry_allowed(logic [2:0] mode, logic [1:0] used,
                                         logic [1:0] limit);
    return (mode == MODE_AUTO) && (used < limit);
  endfunction

  function automatic logic [STAT_W-1:0] err_to_status(logic crc, logic cmd,
                                                      logic id, logic tmo);
    logic [STAT_W-1:0] w;
    w          = '0;
    w[BIT_CRC] = crc;
    w[BIT_CMD] = cmd;
    w[BIT_ID]  = id;
    w[BIT_TMO] = tmo;
    return w;
  endfunction

endpackage

// File: rtl/cfg_rcfg_filter.sv
module cfg_rcfg_filter #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic evt
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

  logic s1_q, s2_q, s2_d_q;
  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s2_d_q <= 1'b1;
      low_q  <= '0;
    end else begin
      s1_q   <= pin_n;
      s2_q   <= s1_q;
      s2_d_q <= s2_q;
      if (s2_q)              low_q <= '0;
      else if (low_q != SAT) low_q <= low_q + 1'b1;
    end
  end

  // release edge of a pulse that was long enough
  assign evt = s2_q && !s2_d_q && (low_q >= SAT);

  // R3
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/cfg_load_timer.sv
module cfg_load_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  // R10
  tmo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              crc_err,
  input  logic              cmd_err,
  input  logic              id_err,
  input  logic              tmo_err,
  input  logic              set_done,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] st_q;
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    set_vec           = err_to_status(crc_err, cmd_err, id_err, tmo_err);
    set_vec[BIT_DONE] = set_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (clr) st_q <= '0;
    else          st_q <= st_q | set_vec;
  end

  assign status = st_q;

  // R11
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((st_q & $past(st_q)) == $past(st_q)));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS    = 8000,
  parameter int unsigned MIN_PULSE_PS     = 25000,
  parameter bit          EXTRA_RETRY      = 1'b1,
  parameter int unsigned LOAD_TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              rcfg_n,
  input  logic [2:0]        mode_pins,
  input  logic              refresh_cmd,
  input  logic              att_id_err,
  input  logic              att_crc_err,
  input  logic              att_cmd_err,
  input  logic              att_data_done,
  output logic              ready,
  output logic              done,
  output logic [2:0]        mode_latched,
  output logic              load_start,
  output logic [STAT_W-1:0] err_status,
  output logic [1:0]        retry_cnt
);
  localparam int unsigned MIN_LOW = min_low_cycles(MIN_PULSE_PS, CLK_PERIOD_PS);
  localparam logic [1:0]  MAX_RETRY = EXTRA_RETRY ? 2'd2 : 2'd0;

  cfg_state_e st_q, st_d;
  logic [2:0] mode_q;
  logic [1:0] retry_q;

  // named internal events
  logic rcfg_evt, tmo_hit, in_load, in_user, in_halt;
  logic any_err, load_fail, load_ok, retry_go;

  cfg_rcfg_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_n(rcfg_n), .evt(rcfg_evt));

  cfg_load_timer #(.LIMIT(LOAD_TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_load), .expire(tmo_hit));

  assign in_load   = (st_q == ST_LOAD);
  assign in_user   = (st_q == ST_USER);
  assign in_halt   = (st_q == ST_HALT);
  assign any_err   = att_id_err | att_crc_err | att_cmd_err | tmo_hit;
  assign load_fail = in_load && any_err;
  assign load_ok   = in_load && !any_err && att_data_done;
  assign retry_go  = retry_allowed(mode_q, retry_q, MAX_RETRY);

  cfg_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_POR),
    .crc_err(in_load && att_crc_err), .cmd_err(in_load && att_cmd_err),
    .id_err(in_load && att_id_err), .tmo_err(tmo_hit),
    .set_done(load_ok), .status(err_status));

  always_comb begin
    st_d = st_q;
    if (!pwr_good) begin
      st_d = ST_POR;
    end else if (st_q != ST_POR && rcfg_evt) begin
      st_d = ST_POR;
    end else begin
      case (st_q)
        ST_POR:  st_d = ST_INIT;
        ST_INIT: st_d = ST_LOAD;
        ST_LOAD: st_d = load_fail ? ST_FAIL : (load_ok ? ST_WAKE : ST_LOAD);
        ST_WAKE: st_d = ST_USER;
        ST_USER: st_d = refresh_cmd ? ST_POR : ST_USER;
        ST_FAIL: st_d = retry_go ? ST_INIT : ST_HALT;
        ST_HALT: st_d = ST_HALT;
        default: st_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_POR;
      mode_q  <= '0;
      retry_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_INIT && st_q != ST_INIT) mode_q <= mode_pins;
      if (st_q == ST_POR)                     retry_q <= '0;
      else if (st_q == ST_FAIL && retry_go && pwr_good && !rcfg_evt)
        retry_q <= retry_q + 1'b1;
    end
  end

  assign ready        = (st_q == ST_INIT) || in_load || (st_q == ST_WAKE) || in_user;
  assign done         = (st_q == ST_WAKE) || in_user;
  assign load_start   = (st_q == ST_INIT);
  assign mode_latched = mode_q;
  assign retry_cnt    = retry_q;

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!ready && !done));
  // R2
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mode_latched == $past(mode_pins)));
  // R2
  start_in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> ready);
  // R4
  fail_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fail && pwr_good && !rcfg_evt) |=> (!ready && !done));
  // R6
  done_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
  // R7
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_user && pwr_good && !rcfg_evt && !refresh_cmd) |=> in_user);
  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= MAX_RETRY);
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && pwr_good && !rcfg_evt) |=> (in_halt && !ready));
  // R10
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && pwr_good && !rcfg_evt) |=> !ready);

endmodule

// File: tb/cfg_seq_ctrl_tb.sv
module cfg_seq_ctrl_tb;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, rcfg_n = 1'b1, refresh_cmd = 1'b0;
  logic [2:0] mode_pins = 3'b000;
  logic att_id_err = 1'b0, att_crc_err = 1'b0, att_cmd_err = 1'b0, att_data_done = 1'b0;
  logic ready, done, load_start;
  logic [2:0] mode_latched;
  logic [31:0] err_status;
  logic [1:0] retry_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_seq_ctrl #(.CLK_PERIOD_PS(8000), .MIN_PULSE_PS(25000), .EXTRA_RETRY(1'b1),
                 .LOAD_TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .rcfg_n(rcfg_n),
    .mode_pins(mode_pins), .refresh_cmd(refresh_cmd), .att_id_err(att_id_err),
    .att_crc_err(att_crc_err), .att_cmd_err(att_cmd_err),
    .att_data_done(att_data_done), .ready(ready), .done(done),
    .mode_latched(mode_latched), .load_start(load_start),
    .err_status(err_status), .retry_cnt(retry_cnt));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_flags();
    att_id_err = 0; att_crc_err = 0; att_cmd_err = 0; att_data_done = 0;
  endtask

  // power cycle, return at the first loading cycle
  task automatic power_up(logic [2:0] m);
    step(); pwr_good = 0;
    step();
    check("R1 por ready", ready, 0);
    check("R1 por done", done, 0);
    pwr_good = 1; mode_pins = m;
    step();
    check("R2 ready rise", ready, 1);
    check("R2 load_start", load_start, 1);
    check("R2 mode latch", mode_latched, m);
    check("R11 status clear", err_status, 0);
    check("R1 retry clear", retry_cnt, 0);
    step();
    check("R2 start single", load_start, 0);
  endtask

  task automatic pulse_pin(int n);
    rcfg_n = 0;
    repeat (n) step();
    rcfg_n = 1;
  endtask

  // mode | id crc cmd dn | exp ready done | low4 | bit13
  localparam int NV = 7;
  localparam logic [13:0] VEC [NV] = '{
    {3'b000, 4'b0001, 2'b11, 4'b0000, 1'b1},
    {3'b001, 4'b0100, 2'b00, 4'b0001, 1'b0},
    {3'b011, 4'b0010, 2'b00, 4'b0010, 1'b0},
    {3'b101, 4'b1000, 2'b00, 4'b0100, 1'b0},
    {3'b111, 4'b0101, 2'b00, 4'b0001, 1'b0},
    {3'b010, 4'b1010, 2'b00, 4'b0110, 1'b0},
    {3'b110, 4'b0001, 2'b11, 4'b0000, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    check("R1 reset ready", ready, 0);
    check("R1 reset done", done, 0);
    check("R1 reset status", err_status, 0);
    check("R1 reset retry", retry_cnt, 0);
    rst_n = 1;
    step();
    check("R1 no power ready", ready, 0);

    // table: R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      power_up(VEC[i][13:11]);
      att_id_err = VEC[i][10]; att_crc_err = VEC[i][9];
      att_cmd_err = VEC[i][8]; att_data_done = VEC[i][7];
      step();
      clear_flags();
      check("R4/R5/R6 ready", ready, VEC[i][6]);
      check("R4/R5/R6 done", done, VEC[i][5]);
      check("R4 status low bits", err_status[3:0], VEC[i][4:1]);
      check("R6 done-final bit", err_status[13], VEC[i][0]);
    end

    // user mode robustness
    power_up(3'b000);
    att_data_done = 1; step(); clear_flags();
    step();
    att_crc_err = 1; att_id_err = 1; step(); clear_flags();
    step();
    check("R7 errors ignored done", done, 1);
    check("R7 errors ignored status", err_status, 32'h0000_2000);
    pulse_pin(3);
    repeat (5) step();
    check("R3 short pulse ignored", done, 1);
    check("R3 short pulse ready", ready, 1);
    pulse_pin(4);
    step(); step();
    check("R3 not yet", ready, 1);
    step();
    check("R3 restart ready low", ready, 0);
    check("R3 restart done low", done, 0);
    step();
    check("R3 restart ready high", ready, 1);
    check("R3 restart start", load_start, 1);
    check("R11 pin clears status", err_status, 0);

    // refresh from user
    step(); att_data_done = 1; step(); clear_flags();
    step();
    refresh_cmd = 1; step(); refresh_cmd = 0;
    check("R7 refresh ready low", ready, 0);
    check("R7 refresh done low", done, 0);
    step();
    check("R7 refresh restarts", load_start, 1);

    // automatic retries
    step(); att_crc_err = 1; step(); clear_flags();
    check("R8 fail ready low", ready, 0);
    check("R8 retry before", retry_cnt, 0);
    step();
    check("R8 retry ready high", ready, 1);
    check("R8 retry start", load_start, 1);
    check("R8 retry count 1", retry_cnt, 1);
    step(); att_cmd_err = 1; step(); clear_flags();
    step();
    check("R8 retry count 2", retry_cnt, 2);
    check("R11 sticky across retry", err_status[3:0], 4'b0011);
    step(); att_id_err = 1; step(); clear_flags();
    step();
    check("R9 exhausted ready", ready, 0);
    check("R9 exhausted done", done, 0);
    check("R11 sticky three", err_status[3:0], 4'b0111);
    refresh_cmd = 1; step(); refresh_cmd = 0;
    repeat (3) step();
    check("R9 refresh ignored", ready, 0);
    check("R9 refresh ignored retry", retry_cnt, 2);
    pulse_pin(4);
    repeat (3) step();
    check("R9 pin restart low", ready, 0);
    step();
    check("R9 pin restart high", ready, 1);
    check("R11 retry cleared", retry_cnt, 0);
    check("R11 status cleared", err_status, 0);

    // timeout in non-auto mode
    power_up(3'b001);
    repeat (TMO - 1) step();
    check("R10 before timeout", ready, 1);
    step();
    check("R10 timeout ready", ready, 0);
    check("R10 timeout bit", err_status[3:0], 4'b1000);
    step(); step();
    check("R9 no retry other mode", retry_cnt, 0);
    check("R9 parked", ready, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule